// File: doc/BRIEF.md
# Two-Wide Register Rename Map with Free List

This block renames the architected registers of up to two instructions per cycle onto a larger pool of physical registers. It holds a map table that records the current physical register for each architected register. It also holds a first-in first-out pool of unused physical registers and one ready flag per physical register. Each slot presents two source indices and one destination index. The block returns physical tags and ready flags for the sources, a fresh tag for the destination, and the mapping that the destination displaces.

The second slot is checked against the first slot in the same cycle. If it reads the register that the first slot writes, it gets the first slot's new tag. If both slots write the same register, the later write wins. A displaced mapping is returned to the pool only through the commit port, when the instruction that overwrote it retires. A writeback port marks a physical register as ready. A synchronous flush returns every structure to its reset contents.

Each cycle the rename decision takes one of three named states. RN_IDLE means no slot is valid or a flush is active. RN_FIRE means the pool can cover every requested destination, so the pair is renamed at the next edge. RN_STALL means the pool is short: nothing changes and the stall output is raised. The state moves from RN_IDLE or RN_STALL to RN_FIRE as soon as enough tags are free. It moves to RN_STALL whenever valid slots need more tags than the pool holds.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architected register i maps to physical tag i, every physical register is ready, and the pool holds tags 32 to 63 with 32 at its head.
- R2: Each valid slot whose destination index is nonzero receives the tag at the head of the pool. Slot 0 is served before slot 1, and allocation follows first-in first-out order.
- R3: Source tags come from the map table as it stood before this cycle's destinations are installed, so a slot that reads and writes the same register sees the old tag.
- R4: A newly allocated tag reads as not ready until a writeback names it. A writeback makes the tag read as ready from the next cycle on.
- R5: A slot 1 source equal to a nonzero slot 0 destination takes slot 0's new tag and is reported not ready.
- R6: pold_o gives the mapping that the destination displaces. For slot 1 this is slot 0's new tag when both slots write the same register. It is 0 when no destination is renamed.
- R7: When both slots write the same architected register, the table keeps slot 1's tag afterwards.
- R8: A commit appends its tag to the tail of the pool. That tag can be allocated from the next cycle on, after the tags already waiting in the pool.
- R9: When the valid slots need more tags than the pool holds, stall_o is 1, fire_o is 0, and neither the table, the pool nor the ready flags change from renaming.
- R10: Architected register 0 is never renamed. As a source it reads tag 0 as ready. As a destination it gets pdst_o = 0 and takes nothing from the pool.
- R11: A cycle with flush_i high restores the R1 state at the next edge, and no rename fires in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Synchronous return to the reset state |
| slot_vld_i | input | 2 | Per-slot valid |
| src_a_i | input | 2x5 | First source index per slot |
| src_b_i | input | 2x5 | Second source index per slot |
| dst_i | input | 2x5 | Destination index per slot (0 = none) |
| cm_vld_i | input | 1 | Commit returns a tag |
| cm_tag_i | input | 6 | Tag freed by commit |
| wb_vld_i | input | 1 | Writeback valid |
| wb_tag_i | input | 6 | Tag whose value is now written |
| fire_o | output | 1 | The pair is renamed at this edge |
| stall_o | output | 1 | Pool too short for the valid slots |
| ptag_a_o | output | 2x6 | Physical tag of first source |
| rdy_a_o | output | 2 | Ready flag of first source |
| ptag_b_o | output | 2x6 | Physical tag of second source |
| rdy_b_o | output | 2 | Ready flag of second source |
| pdst_o | output | 2x6 | New destination tag |
| pold_o | output | 2x6 | Displaced previous mapping |

## Verification
The bench goes after intra-pair dependences in which slot 1 reads or rewrites slot 0's destination. A design without the bypass would hand slot 1 a stale tag or keep slot 0's mapping. It also drains the pool to empty and to a single free tag. A wrong need count would then fire with too few tags or stall while one destination-less slot could go ahead. Tags are recycled through commit so that first-in first-out reuse shows up, and a design that freed tags early or out of order would hand out the wrong tag. A flush in the middle of traffic must bring the first allocations back to 32 and 33.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
    typedef enum logic [1:0] {
        RN_IDLE  = 2'd0,
        RN_FIRE  = 2'd1,
        RN_STALL = 2'd2
    } rn_state_e;
endpackage

// File: rtl/rmap_table.sv
module rmap_table #(
    parameter int ARCH_N = 32,
    parameter int PHYS_N = 64,
    parameter int SLOTS  = 2,
    parameter int RP     = 6,
    localparam int AW    = $clog2(ARCH_N),
    localparam int PW    = $clog2(PHYS_N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic [RP-1:0][AW-1:0]     rd_idx_i,
    output logic [RP-1:0][PW-1:0]     rd_tag_o,
    input  logic [SLOTS-1:0]          we_i,
    input  logic [SLOTS-1:0][AW-1:0]  widx_i,
    input  logic [SLOTS-1:0][PW-1:0]  wtag_i
);
    logic [PW-1:0] map_q [ARCH_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ARCH_N; k++) map_q[k] <= PW'(k);
        end else if (flush_i) begin
            for (int k = 0; k < ARCH_N; k++) map_q[k] <= PW'(k);
        end else begin
            // later slots override earlier ones (R7)
            for (int s = 0; s < SLOTS; s++)
                if (we_i[s]) map_q[widx_i[s]] <= wtag_i[s];
        end
    end

    genvar g;
    generate
        for (g = 0; g < RP; g++) begin : g_rd
            assign rd_tag_o[g] = map_q[rd_idx_i[g]];
        end
    endgenerate

    p_last_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i[SLOTS-1] && !flush_i) |=> (map_q[$past(widx_i[SLOTS-1])] == $past(wtag_i[SLOTS-1])));

    p_zero_never_mapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (map_q[0] == '0));
endmodule

// File: rtl/rmap_freelist.sv
module rmap_freelist #(
    parameter int ARCH_N = 32,
    parameter int PHYS_N = 64,
    parameter int SLOTS  = 2,
    localparam int PW    = $clog2(PHYS_N),
    localparam int CW    = $clog2(PHYS_N + 1),
    localparam int NW    = $clog2(SLOTS + 1),
    localparam int FREE_N = PHYS_N - ARCH_N
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic [NW-1:0]             pop_n_i,
    input  logic                      push_i,
    input  logic [PW-1:0]             push_tag_i,
    output logic [SLOTS-1:0][PW-1:0]  head_o,
    output logic [CW-1:0]             avail_o
);
    logic [PW-1:0] slot_q [PHYS_N];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < PHYS_N; k++)
                slot_q[k] <= (k < FREE_N) ? PW'(ARCH_N + k) : '0;
            rd_q  <= '0;
            wr_q  <= PW'(FREE_N);
            cnt_q <= CW'(FREE_N);
        end else if (flush_i) begin
            for (int k = 0; k < PHYS_N; k++)
                slot_q[k] <= (k < FREE_N) ? PW'(ARCH_N + k) : '0;
            rd_q  <= '0;
            wr_q  <= PW'(FREE_N);
            cnt_q <= CW'(FREE_N);
        end else begin
            if (push_i) begin
                slot_q[wr_q] <= push_tag_i;
                wr_q         <= wr_q + 1'b1;
            end
            rd_q  <= rd_q + PW'(pop_n_i);
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_n_i);
        end
    end

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_head
            assign head_o[g] = slot_q[rd_q + PW'(g)];
        end
    endgenerate

    assign avail_o = cnt_q;

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |-> (CW'(pop_n_i) <= cnt_q));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush_i) |-> (cnt_q < CW'(PHYS_N)));
endmodule

// File: rtl/rmap_ready.sv
module rmap_ready #(
    parameter int PHYS_N = 64,
    parameter int SLOTS  = 2,
    parameter int RP     = 4,
    localparam int PW    = $clog2(PHYS_N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic [RP-1:0][PW-1:0]     rd_tag_i,
    output logic [RP-1:0]             rd_rdy_o,
    input  logic                      set_i,
    input  logic [PW-1:0]             set_tag_i,
    input  logic [SLOTS-1:0]          clr_i,
    input  logic [SLOTS-1:0][PW-1:0]  clr_tag_i
);
    logic [PHYS_N-1:0] rdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= '1;
        end else if (flush_i) begin
            rdy_q <= '1;
        end else begin
            if (set_i) rdy_q[set_tag_i] <= 1'b1;
            for (int s = 0; s < SLOTS; s++)
                if (clr_i[s]) rdy_q[clr_tag_i[s]] <= 1'b0;
        end
    end

    genvar g;
    generate
        for (g = 0; g < RP; g++) begin : g_rd
            assign rd_rdy_o[g] = rdy_q[rd_tag_i[g]];
        end
    endgenerate

    p_alloc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[0] && !flush_i && !(set_i && set_tag_i == clr_tag_i[0]))
        |=> !rdy_q[$past(clr_tag_i[0])]);

    p_wb_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !flush_i && !(|clr_i)) |=> rdy_q[$past(set_tag_i)]);
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
    parameter int ARCH_N = 32,
    parameter int PHYS_N = 64,
    parameter int SLOTS  = 2,
    localparam int AW    = $clog2(ARCH_N),
    localparam int PW    = $clog2(PHYS_N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic [SLOTS-1:0]          slot_vld_i,
    input  logic [SLOTS-1:0][AW-1:0]  src_a_i,
    input  logic [SLOTS-1:0][AW-1:0]  src_b_i,
    input  logic [SLOTS-1:0][AW-1:0]  dst_i,
    input  logic                      cm_vld_i,
    input  logic [PW-1:0]             cm_tag_i,
    input  logic                      wb_vld_i,
    input  logic [PW-1:0]             wb_tag_i,
    output logic                      fire_o,
    output logic                      stall_o,
    output logic [SLOTS-1:0][PW-1:0]  ptag_a_o,
    output logic [SLOTS-1:0]          rdy_a_o,
    output logic [SLOTS-1:0][PW-1:0]  ptag_b_o,
    output logic [SLOTS-1:0]          rdy_b_o,
    output logic [SLOTS-1:0][PW-1:0]  pdst_o,
    output logic [SLOTS-1:0][PW-1:0]  pold_o
);
    import rmap_pkg::*;

    localparam int CW  = $clog2(PHYS_N + 1);
    localparam int NW  = $clog2(SLOTS + 1);
    localparam int MRP = 3 * SLOTS;
    localparam int RRP = 2 * SLOTS;

    logic [MRP-1:0][AW-1:0]   map_idx;
    logic [MRP-1:0][PW-1:0]   map_tag;
    logic [RRP-1:0][PW-1:0]   rdy_idx;
    logic [RRP-1:0]           rdy_val;
    logic [SLOTS-1:0][PW-1:0] fl_head;
    logic [CW-1:0]            fl_avail;
    logic [SLOTS-1:0]         has_dst;
    logic [SLOTS-1:0][PW-1:0] new_tag;
    logic [NW-1:0]            need;
    logic [SLOTS-1:0]         we;
    rn_state_e                rn_state;
    logic                     fire;

    // table lookups: a, b, dst per slot
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            map_idx[3*i]   = src_a_i[i];
            map_idx[3*i+1] = src_b_i[i];
            map_idx[3*i+2] = dst_i[i];
            rdy_idx[2*i]   = map_tag[3*i];
            rdy_idx[2*i+1] = map_tag[3*i+1];
        end
    end

    // allocation of pool heads in slot order (R2, R10)
    always_comb begin
        int na;
        na = 0;
        for (int i = 0; i < SLOTS; i++) begin
            has_dst[i] = slot_vld_i[i] && (dst_i[i] != '0);
            new_tag[i] = '0;
            if (has_dst[i]) begin
                for (int k = 0; k < SLOTS; k++)
                    if (k == na) new_tag[i] = fl_head[k];
                na = na + 1;
            end
        end
        need = NW'(na);
    end

    // rename decision
    always_comb begin
        rn_state = RN_IDLE;
        if (!flush_i && (|slot_vld_i))
            rn_state = (CW'(need) <= fl_avail) ? RN_FIRE : RN_STALL;
    end

    always_comb begin
        fire    = 1'b0;
        stall_o = 1'b0;
        unique case (rn_state)
            RN_IDLE:  ;
            RN_FIRE:  fire = 1'b1;
            RN_STALL: stall_o = 1'b1;
            default:  ;
        endcase
    end
    assign fire_o = fire;

    // source and displaced-mapping resolution with intra-pair bypass (R3, R5, R6)
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            ptag_a_o[i] = map_tag[3*i];
            rdy_a_o[i]  = rdy_val[2*i];
            ptag_b_o[i] = map_tag[3*i+1];
            rdy_b_o[i]  = rdy_val[2*i+1];
            pold_o[i]   = has_dst[i] ? map_tag[3*i+2] : '0;
            for (int j = 0; j < i; j++) begin
                if (has_dst[j] && dst_i[j] == src_a_i[i]) begin
                    ptag_a_o[i] = new_tag[j];
                    rdy_a_o[i]  = 1'b0;
                end
                if (has_dst[j] && dst_i[j] == src_b_i[i]) begin
                    ptag_b_o[i] = new_tag[j];
                    rdy_b_o[i]  = 1'b0;
                end
                if (has_dst[i] && has_dst[j] && dst_i[j] == dst_i[i])
                    pold_o[i] = new_tag[j];
            end
            pdst_o[i] = new_tag[i];
            we[i]     = fire && has_dst[i];
        end
    end

    rmap_table #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .SLOTS(SLOTS), .RP(MRP)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush_i),
        .rd_idx_i (map_idx),
        .rd_tag_o (map_tag),
        .we_i     (we),
        .widx_i   (dst_i),
        .wtag_i   (new_tag)
    );

    rmap_freelist #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .SLOTS(SLOTS)) u_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .pop_n_i    (fire ? need : NW'(0)),
        .push_i     (cm_vld_i && !flush_i),
        .push_tag_i (cm_tag_i),
        .head_o     (fl_head),
        .avail_o    (fl_avail)
    );

    rmap_ready #(.PHYS_N(PHYS_N), .SLOTS(SLOTS), .RP(RRP)) u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .rd_tag_i  (rdy_idx),
        .rd_rdy_o  (rdy_val),
        .set_i     (wb_vld_i && !flush_i && wb_tag_i != '0),
        .set_tag_i (wb_tag_i),
        .clr_i     (we),
        .clr_tag_i (new_tag)
    );

    p_fresh_distinct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && has_dst[0] && has_dst[1]) |-> (pdst_o[0] != pdst_o[1]));

    p_zero_src_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld_i[0] && src_a_i[0] == '0) |-> (ptag_a_o[0] == '0 && rdy_a_o[0]));

    p_fire_stall_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_o && stall_o));

    p_flush_no_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !fire_o);
endmodule

// File: tb/rename_map_unit_tb.sv
module rename_map_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [1:0] vld = '0;
    logic [1:0][4:0] sa = '0, sb = '0, sd = '0;
    logic cm_vld = 1'b0, wb_vld = 1'b0;
    logic [5:0] cm_tag = '0, wb_tag = '0;
    logic fire, stall;
    logic [1:0][5:0] pta, ptb, pdst, pold;
    logic [1:0] ra, rb;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_map_unit dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .slot_vld_i(vld),
        .src_a_i(sa), .src_b_i(sb), .dst_i(sd),
        .cm_vld_i(cm_vld), .cm_tag_i(cm_tag), .wb_vld_i(wb_vld), .wb_tag_i(wb_tag),
        .fire_o(fire), .stall_o(stall),
        .ptag_a_o(pta), .rdy_a_o(ra), .ptag_b_o(ptb), .rdy_b_o(rb),
        .pdst_o(pdst), .pold_o(pold)
    );

    int n_cmp = 0, n_bad = 0;
    int map_m [32];
    bit rdy_m [64];
    int freeq [$];
    int cmq [$];
    int wbq [$];
    string phase = "R1";
    bit commit_en = 1'b1;

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) %s: actual=%0d expected=%0d", req, phase, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) map_m[i] = i;
        for (int i = 0; i < 64; i++) rdy_m[i] = 1'b1;
        freeq.delete(); cmq.delete(); wbq.delete();
        for (int i = 32; i < 64; i++) freeq.push_back(i);
    endtask

    // compare this cycle's outputs against the model, then advance the model
    task automatic compare_and_step();
        int need, na;
        bit any, ef, es;
        bit hd [2];
        int pd [2];
        int ta, tb, to;
        bit xa, xb;
        string qa, qb;
        #1;
        any = |vld;
        need = 0;
        for (int i = 0; i < 2; i++) begin
            hd[i] = vld[i] && (sd[i] != 0);
            if (hd[i]) need++;
        end
        ef = !flush && any && (need <= freeq.size());
        es = !flush && any && !ef;
        chk("R9", "stall_o", int'(stall), int'(es));
        chk("R9", "fire_o", int'(fire), int'(ef));
        if (ef) begin
            na = 0;
            for (int i = 0; i < 2; i++) begin
                pd[i] = 0;
                if (hd[i]) begin pd[i] = freeq[na]; na++; end
            end
            for (int i = 0; i < 2; i++) begin
                ta = map_m[sa[i]]; xa = rdy_m[ta]; qa = (sa[i] == 0) ? "R10" : "R3";
                tb = map_m[sb[i]]; xb = rdy_m[tb]; qb = (sb[i] == 0) ? "R10" : "R3";
                to = hd[i] ? map_m[sd[i]] : 0;
                if (i == 1 && hd[0]) begin
                    if (sd[0] == sa[1]) begin ta = pd[0]; xa = 1'b0; qa = "R5"; end
                    if (sd[0] == sb[1]) begin tb = pd[0]; xb = 1'b0; qb = "R5"; end
                    if (hd[1] && sd[0] == sd[1]) to = pd[0];
                end
                chk(qa, $sformatf("ptag_a[%0d]", i), int'(pta[i]), ta);
                chk((qa == "R3") ? "R4" : qa, $sformatf("rdy_a[%0d]", i), int'(ra[i]), int'(xa));
                chk(qb, $sformatf("ptag_b[%0d]", i), int'(ptb[i]), tb);
                chk((qb == "R3") ? "R4" : qb, $sformatf("rdy_b[%0d]", i), int'(rb[i]), int'(xb));
                chk(hd[i] ? "R2" : "R10", $sformatf("pdst[%0d]", i), int'(pdst[i]), pd[i]);
                chk("R6", $sformatf("pold[%0d]", i), int'(pold[i]), to);
            end
        end
        // advance model as the design will at the coming edge
        if (flush) begin
            model_reset();
        end else begin
            if (wb_vld && wb_tag != 0) rdy_m[wb_tag] = 1'b1;
            if (ef) begin
                for (int i = 0; i < need; i++) void'(freeq.pop_front());
                for (int i = 0; i < 2; i++) if (hd[i]) begin
                    cmq.push_back((i == 1 && hd[0] && sd[0] == sd[1]) ? pd[0] : map_m[sd[i]]);
                    rdy_m[pd[i]] = 1'b0;
                    map_m[sd[i]] = pd[i];
                    wbq.push_back(pd[i]);
                end
            end
            if (cm_vld) freeq.push_back(int'(cm_tag));
        end
    endtask

    task automatic drive(bit [1:0] v, int a0, int b0, int d0, int a1, int b1, int d1,
                         bit c, bit w, bit f);
        @(negedge clk);
        vld = v; flush = f;
        sa[0] = 5'(a0); sb[0] = 5'(b0); sd[0] = 5'(d0);
        sa[1] = 5'(a1); sb[1] = 5'(b1); sd[1] = 5'(d1);
        cm_vld = 1'b0; wb_vld = 1'b0;
        if (c && !f && cmq.size() > 0) begin cm_vld = 1'b1; cm_tag = 6'(cmq.pop_front()); end
        if (w && !f && wbq.size() > 0) begin wb_vld = 1'b1; wb_tag = 6'(wbq.pop_front()); end
        compare_and_step();
    endtask

    task automatic rand_cycle(bit allow_ren);
        bit [1:0] v;
        v = allow_ren ? 2'($urandom_range(3, 0)) : 2'b00;
        drive(v, $urandom_range(7, 0), $urandom_range(7, 0), $urandom_range(7, 0),
                 $urandom_range(7, 0), $urandom_range(7, 0), $urandom_range(7, 0),
              commit_en && ($urandom_range(2, 0) != 0), $urandom_range(1, 0) == 1, 1'b0);
    endtask

    task automatic pair_scenario();
        // slot0: r5 <- r5, r0 ; slot1: r5 <- r5, r3 (R3, R5, R6, R7, R10)
        drive(2'b11, 5, 0, 5, 5, 3, 5, 1'b0, 1'b0, 1'b0);
        phase = "R7";
        // r5 now maps to slot 1's tag, not ready until writeback
        drive(2'b01, 5, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        drive(2'b00, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        drive(2'b00, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        drive(2'b01, 5, 5, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        drive(2'b00, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        pair_scenario();

        phase = "random";
        repeat (400) rand_cycle(1'b1);

        phase = "R9";
        commit_en = 1'b0;
        for (int k = 0; k < 40; k++)
            drive(2'b11, k % 8, (k + 3) % 8, 1 + k % 7, (k + 1) % 8, 2, 1 + (k + 2) % 7,
                  1'b0, 1'b1, 1'b0);
        // one slot without a destination still fires while pool is empty
        drive(2'b01, 1, 2, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);

        phase = "R8";
        commit_en = 1'b1;
        repeat (60) drive(2'b00, 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 1'b0);
        repeat (40) drive(2'b11, 1, 2, 3, 3, 4, 3, 1'b0, 1'b1, 1'b0);

        phase = "random2";
        repeat (300) rand_cycle(1'b1);

        phase = "R11";
        drive(2'b11, 1, 2, 3, 4, 5, 6, 1'b0, 1'b0, 1'b1);
        pair_scenario();

        phase = "random3";
        repeat (300) rand_cycle(1'b1);

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule